// File: doc/BRIEF.md
# Dual-Channel IQ Sample Packer

This block sits between a two-channel receive sample source and a DMA engine. On every cycle that its input strobe is high it takes one 12-bit I and one 12-bit Q component from each of two receive channels. It packs the four components into a continuous 64-bit word stream with a valid/ready handshake. A two-bit format selector picks how many bits each component costs on the link. The wide format keeps every component in a sign-extended 16-bit slot, which the host can read directly. The dense format keeps all 12 bits with no padding, so components straddle word boundaries. The narrow format keeps only the top 8 bits and gives up dynamic range to halve the bandwidth.

Packing runs through a 128-bit accumulator. New components are appended above the bits already held. The low 64 bits are offered as an output word whenever at least 64 bits are held. A format change waits until the accumulator is empty, so one word never carries two formats. When the consumer stalls and the next input would not fit, that input is discarded and a drop counter advances.

Top module: `iqp_packer`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid is low and drop_count is zero. The accumulator starts empty and the active format starts as wide.
- R2: Wide format (selector 0): each component is sign-extended from 12 to 16 bits. Each accepted input cycle adds 64 bits, one full output word.
- R3: Dense format (selector 1): each component takes exactly 12 bits with no padding. Bits run on from one output word into the next, so four input cycles fill exactly three words.
- R4: Narrow format (selector 2): each component is reduced to its bits [11:4]. Each input cycle adds 32 bits, so two cycles fill one word.
- R5: Within one input cycle the components are laid down in the order channel 0 I, channel 0 Q, channel 1 I, channel 1 Q. Each component's bit 0 comes first. The stream fills each output word from bit 0 upward, and earlier input cycles land in lower bits or earlier words.
- R6: Selector value 3 is treated as the wide format. The selector is sampled only on a cycle where the accumulator holds no bits once any output transfer in that cycle is counted. On every other cycle the previously latched format stays in force.
- R7: An input cycle is accepted only if the bits held after any same-cycle output transfer, plus the bits the input adds, total no more than 128. Otherwise the whole input cycle is discarded and drop_count goes up by exactly one, wrapping at its width.
- R8: out_valid is high exactly when at least 64 bits are held, and out_data is the oldest 64 held bits. While out_valid is high and out_ready is low, out_data holds still. One word leaves on each cycle where both are high, and an input can be accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Format selector: 0 wide, 1 dense, 2 narrow, 3 as wide |
| in_valid | input | 1 | Input sample strobe |
| in_i0 | input | 12 | Channel 0 in-phase component |
| in_q0 | input | 12 | Channel 0 quadrature component |
| in_i1 | input | 12 | Channel 1 in-phase component |
| in_q1 | input | 12 | Channel 1 quadrature component |
| out_data | output | 64 | Packed output word |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the word |
| drop_count | output | 16 | Count of discarded input cycles (wrapping) |

## Verification
The bench targets the dense format's word straddling. A packer that padded each input cycle, or that reset its bit offset at each word, would put shifted or zero bits in the second and third words of every group of three. It also switches the selector in the middle of a dense group. A design that switched at once would mix two formats in one word, and the first word after the switch would disagree with the model. Back-pressure is held long enough to fill the accumulator exactly to 128 bits and then past it. An off-by-one in the fit test either drops an input that fits or corrupts held bits, and either way drop_count or later words disagree. Sign extension of negative components and the treatment of selector value 3 are also checked.

// File: rtl/iqp_pkg.sv
package iqp_pkg;

    // Component lanes per input cycle: ch0 I, ch0 Q, ch1 I, ch1 Q
    localparam int N_LANES  = 4;
    // Container width of the wide format
    localparam int WIDE_W   = 16;
    // Kept bits of the narrow format
    localparam int NARROW_W = 8;

    typedef enum logic [1:0] {
        FMT_WIDE   = 2'd0,
        FMT_DENSE  = 2'd1,
        FMT_NARROW = 2'd2,
        FMT_SPARE  = 2'd3
    } fmt_e;

    // Bits one input cycle contributes in a given format
    function automatic int unsigned cycle_bits(fmt_e f, int unsigned comp_w);
        case (f)
            FMT_DENSE:  return N_LANES * comp_w;
            FMT_NARROW: return N_LANES * NARROW_W;
            default:    return N_LANES * WIDE_W;
        endcase
    endfunction

endpackage

// File: rtl/iqp_lane_fmt.sv
module iqp_lane_fmt
    import iqp_pkg::*;
#(
    parameter int COMP_W = 12,
    parameter int WORD_W = 64,
    parameter int LEN_W  = 8
) (
    input  fmt_e                      fmt,
    input  logic [N_LANES*COMP_W-1:0] comps,
    output logic [WORD_W-1:0]         chunk,
    output logic [LEN_W-1:0]          chunk_len
);

    localparam int WIDE_TOT   = N_LANES * WIDE_W;
    localparam int DENSE_TOT  = N_LANES * COMP_W;
    localparam int NARROW_TOT = N_LANES * NARROW_W;

    logic [WIDE_TOT-1:0]   wide_vec;
    logic [DENSE_TOT-1:0]  dense_vec;
    logic [NARROW_TOT-1:0] narrow_vec;

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        logic [COMP_W-1:0] c;
        assign c = comps[k*COMP_W +: COMP_W];
        assign wide_vec[k*WIDE_W +: WIDE_W]       = {{(WIDE_W-COMP_W){c[COMP_W-1]}}, c};
        assign dense_vec[k*COMP_W +: COMP_W]      = c;
        assign narrow_vec[k*NARROW_W +: NARROW_W] = c[COMP_W-1 -: NARROW_W];
    end

    always_comb begin
        chunk = '0;
        case (fmt)
            FMT_DENSE:  chunk[DENSE_TOT-1:0]  = dense_vec;
            FMT_NARROW: chunk[NARROW_TOT-1:0] = narrow_vec;
            default:    chunk[WIDE_TOT-1:0]   = wide_vec;
        endcase
        chunk_len = LEN_W'(cycle_bits(fmt, COMP_W));
    end

endmodule

// File: rtl/iqp_accum.sv
module iqp_accum #(
    parameter int WORD_W = 64,
    parameter int ACC_W  = 2 * WORD_W,
    parameter int CNT_W  = $clog2(ACC_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WORD_W-1:0] chunk,
    input  logic [CNT_W-1:0]  chunk_len,
    input  logic              pop,
    output logic [WORD_W-1:0] word,
    output logic              word_valid,
    output logic              base_empty,
    output logic              fits
);

    logic [ACC_W-1:0] acc_q, base_acc;
    logic [CNT_W-1:0] cnt_q, base_cnt;
    logic [CNT_W:0]   total;
    logic             pop_fire;

    assign word_valid = (cnt_q >= CNT_W'(WORD_W));
    assign word       = acc_q[WORD_W-1:0];
    assign pop_fire   = pop && word_valid;

    always_comb begin
        base_acc   = pop_fire ? (acc_q >> WORD_W) : acc_q;
        base_cnt   = pop_fire ? (cnt_q - CNT_W'(WORD_W)) : cnt_q;
        base_empty = (base_cnt == '0);
        total      = {1'b0, base_cnt} + {1'b0, chunk_len};
        fits       = (total <= (CNT_W+1)'(ACC_W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (push && fits) begin
            acc_q <= base_acc | (ACC_W'(chunk) << base_cnt);
            cnt_q <= base_cnt + chunk_len;
        end else begin
            acc_q <= base_acc;
            cnt_q <= base_cnt;
        end
    end

endmodule

// File: rtl/iqp_packer.sv
module iqp_packer
    import iqp_pkg::*;
#(
    parameter int COMP_W = 12,
    parameter int WORD_W = 64,
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        fmt_sel,
    input  logic              in_valid,
    input  logic [COMP_W-1:0] in_i0,
    input  logic [COMP_W-1:0] in_q0,
    input  logic [COMP_W-1:0] in_i1,
    input  logic [COMP_W-1:0] in_q1,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DROP_W-1:0] drop_count
);

    localparam int ACC_W = 2 * WORD_W;
    localparam int CNT_W = $clog2(ACC_W + 1);

    fmt_e                      fmt_q, fmt_eff;
    logic [N_LANES*COMP_W-1:0] comps;
    logic [WORD_W-1:0]         chunk;
    logic [CNT_W-1:0]          chunk_len;
    logic                      base_empty, fits;
    logic [DROP_W-1:0]         drop_q;

    // Lane order: ch0 I at the bottom, ch1 Q at the top
    assign comps   = {in_q1, in_i1, in_q0, in_i0};
    assign fmt_eff = base_empty ? fmt_e'(fmt_sel) : fmt_q;

    iqp_lane_fmt #(
        .COMP_W (COMP_W),
        .WORD_W (WORD_W),
        .LEN_W  (CNT_W)
    ) u_fmt (
        .fmt       (fmt_eff),
        .comps     (comps),
        .chunk     (chunk),
        .chunk_len (chunk_len)
    );

    iqp_accum #(
        .WORD_W (WORD_W),
        .ACC_W  (ACC_W),
        .CNT_W  (CNT_W)
    ) u_acc (
        .clk        (clk),
        .rst        (rst),
        .push       (in_valid),
        .chunk      (chunk),
        .chunk_len  (chunk_len),
        .pop        (out_ready),
        .word       (out_data),
        .word_valid (out_valid),
        .base_empty (base_empty),
        .fits       (fits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q  <= FMT_WIDE;
            drop_q <= '0;
        end else begin
            fmt_q <= fmt_eff;
            if (in_valid && !fits) drop_q <= drop_q + 1'b1;
        end
    end

    assign drop_count = drop_q;

endmodule

// File: rtl/iqp_packer_chk.sv
module iqp_packer_chk #(
    parameter int WORD_W = 64,
    parameter int DROP_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [WORD_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DROP_W-1:0] drop_count
);

    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (!out_valid && drop_count == '0)); // R1

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

    AST_DROP_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (drop_count == $past(drop_count) ||
                  drop_count == DROP_W'($past(drop_count) + 1'b1))); // R7

    AST_NO_DROP_IF_ROOM: assert property (@(posedge clk) disable iff (rst)
        (!out_valid || !in_valid) |=> $stable(drop_count)); // R7

endmodule

bind iqp_packer iqp_packer_chk #(
    .WORD_W (WORD_W),
    .DROP_W (DROP_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .drop_count (drop_count)
);

// File: tb/sim_iqp_packer.sv
module sim_iqp_packer;

    localparam int CLK_PERIOD = 10;
    localparam int COMP_W = 12;
    localparam int WORD_W = 64;
    localparam int DROP_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        fmt_sel = 2'd0;
    logic              in_valid = 1'b0;
    logic [COMP_W-1:0] in_i0 = '0, in_q0 = '0, in_i1 = '0, in_q1 = '0;
    logic [WORD_W-1:0] out_data;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [DROP_W-1:0] drop_count;

    int n_vec  = 0;
    int n_fail = 0;
    string tag = "R1";

    // Behavioural model: a plain bit queue, oldest bit first
    bit       mq[$];
    int       mdrop = 0;
    int       mfmt  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iqp_packer #(
        .COMP_W (COMP_W),
        .WORD_W (WORD_W),
        .DROP_W (DROP_W)
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .fmt_sel    (fmt_sel),
        .in_valid   (in_valid),
        .in_i0      (in_i0),
        .in_q0      (in_q0),
        .in_i1      (in_i1),
        .in_q1      (in_q1),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .drop_count (drop_count)
    );

    function automatic int comp_width(int f);
        if (f == 1) return 12;
        if (f == 2) return 8;
        return 16; // 0 and 3 (R6)
    endfunction

    task automatic compare();
        logic              exp_v;
        logic [WORD_W-1:0] exp_d;
        logic [DROP_W-1:0] exp_drop;
        n_vec++;
        exp_v    = (mq.size() >= WORD_W);
        exp_drop = DROP_W'(mdrop);
        exp_d    = '0;
        if (exp_v) for (int b = 0; b < WORD_W; b++) exp_d[b] = mq[b];
        if (out_valid !== exp_v) begin
            n_fail++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", tag, out_valid, exp_v);
        end else if (exp_v && out_data !== exp_d) begin
            n_fail++;
            $display("FAIL %s out_data actual=%h expected=%h", tag, out_data, exp_d);
        end else if (drop_count !== exp_drop) begin
            n_fail++;
            $display("FAIL %s drop_count actual=%0d expected=%0d", tag, drop_count, exp_drop);
        end
    endtask

    task automatic model_step(int f, bit v, bit r, logic [COMP_W-1:0] c0,
                              logic [COMP_W-1:0] c1, logic [COMP_W-1:0] c2,
                              logic [COMP_W-1:0] c3);
        logic [COMP_W-1:0] cv [4];
        int base, w;
        cv[0] = c0; cv[1] = c1; cv[2] = c2; cv[3] = c3;
        if (mq.size() >= WORD_W && r)
            for (int b = 0; b < WORD_W; b++) void'(mq.pop_front());
        base = mq.size();
        if (base == 0) mfmt = f;
        w = comp_width(mfmt);
        if (v) begin
            if (base + 4*w > 2*WORD_W) mdrop++;
            else
                for (int k = 0; k < 4; k++)
                    for (int b = 0; b < w; b++) begin
                        if (w == 16)     mq.push_back(b < 12 ? cv[k][b] : cv[k][11]);
                        else if (w == 8) mq.push_back(cv[k][4+b]);
                        else             mq.push_back(cv[k][b]);
                    end
        end
    endtask

    task automatic cycle(int f, bit v, bit r);
        logic [COMP_W-1:0] a, b, c, d;
        @(negedge clk);
        compare();
        a = COMP_W'($urandom); b = COMP_W'($urandom);
        c = COMP_W'($urandom); d = COMP_W'($urandom);
        fmt_sel = 2'(f); in_valid = v; out_ready = r;
        in_i0 = a; in_q0 = b; in_i1 = c; in_q1 = d;
        model_step(f, v, r, a, b, c, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        mq.delete(); mdrop = 0; mfmt = 0;
        @(negedge clk);
        tag = "R1";
        n_vec++;
        if (out_valid !== 1'b0 || drop_count !== '0) begin
            n_fail++;
            $display("FAIL R1 reset state actual=%0b/%0d expected=0/0", out_valid, drop_count);
        end
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        do_reset();

        // R2 wide format, R5 lane order, free-flowing output
        tag = "R2";
        for (int n = 0; n < 20; n++) cycle(0, 1, 1);
        // R2 negative component sign extension: directed extremes
        @(negedge clk); compare();
        fmt_sel = 0; in_valid = 1; out_ready = 1;
        in_i0 = 12'h800; in_q0 = 12'h7FF; in_i1 = 12'hFFF; in_q1 = 12'h001;
        model_step(0, 1, 1, 12'h800, 12'h7FF, 12'h FFF, 12'h001);
        tag = "R5";
        for (int n = 0; n < 4; n++) cycle(0, 0, 1);

        // R3 dense format straddling words
        tag = "R3";
        for (int n = 0; n < 24; n++) cycle(1, 1, 1);
        for (int n = 0; n < 4; n++) cycle(1, 0, 1);

        // R4 narrow format
        tag = "R4";
        for (int n = 0; n < 16; n++) cycle(2, 1, 1);
        for (int n = 0; n < 4; n++) cycle(2, 0, 1);

        // R8 stall with held word, then R7 overflow in wide format
        tag = "R8";
        for (int n = 0; n < 3; n++) cycle(0, 1, 0);
        tag = "R7";
        for (int n = 0; n < 5; n++) cycle(0, 1, 0);
        tag = "R8";
        for (int n = 0; n < 6; n++) cycle(0, 0, 1);

        // R7 dense overflow: 48, 96, then 144 does not fit
        tag = "R7";
        for (int n = 0; n < 4; n++) cycle(1, 1, 0);
        for (int n = 0; n < 6; n++) cycle(1, 0, 1);

        // R6 switch requested mid dense group waits for empty
        tag = "R6";
        do_reset();
        tag = "R6";
        cycle(1, 1, 1);
        for (int n = 0; n < 10; n++) cycle(2, 1, 1);
        for (int n = 0; n < 4; n++) cycle(2, 0, 1);
        // R6 spare selector value behaves as wide
        for (int n = 0; n < 6; n++) cycle(3, 1, 1);
        for (int n = 0; n < 3; n++) cycle(3, 0, 1);

        // Mixed random traffic, R7 and R8 under irregular back-pressure
        tag = "R8";
        for (int n = 0; n < 3000; n++) begin
            int f;
            f = ($urandom % 8 == 0) ? int'($urandom % 4) : int'(fmt_sel);
            cycle(f, ($urandom % 5) != 0, ($urandom % 3) != 0);
        end

        do_reset();
        @(negedge clk); compare();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule